// File: doc/BRIEF.md
# Completion Queue Entry Poster

This block fills a circular completion ring in host memory. A producer hands it completion requests, one per valid/ready handshake. Each request carries a command identifier, a status code, the id of the submission queue it came from, that queue's current head, and a 32-bit result. For each accepted request the block emits one memory write: a byte address inside the ring and a 128-bit formatted entry. It keeps the ring's tail pointer and a phase tag. The phase tag inverts every time the tail wraps and is stored in the least significant bit of each entry's status word. A host can therefore spot fresh entries by comparing that bit with the phase it expects, without reading a count.

The ring is set up by a one-cycle load strobe. The strobe captures the base address, the size field (ring size is the field plus one) and an interrupt enable. It also clears tail and head and sets the phase to 1. The host reports consumed entries through a head-update strobe. When the ring is full, the request ready signal stays low and pending requests wait at the producer. An interrupt request pulses once at the end of each run of back-to-back postings, but only when interrupts were enabled at load.

Top module: `cq_poster`

## Requirements
- R1: After reset no ring is configured: req_ready is 0, and no write or interrupt appears even when req_valid is 1.
- R2: A load strobe sets tail and head to 0 and phase to 1. In the following cycle req_ready is 1, and wr_valid and irq_o are 0.
- R3: An entry accepted in cycle k appears on wr_valid/wr_addr/wr_data in cycle k+1. wr_addr = base + tail × 16 (entry size 2^ES_LOG2 bytes, ES_LOG2 = 4), using the tail before the increment.
- R4: Entry layout: bits [31:0] = result, bits [63:32] = 0, bits [95:64] = {sq_id, sq_head} with sq_id in [95:80], bits [127:96] = {status_word, cid} with the status word in [127:112].
- R5: The status word is {status_code[14:0], phase}, so the phase is bit 112 of wr_data.
- R6: The tail increments after each posting. Posting at tail = size − 1 moves the tail to 0 and inverts the phase for all later entries.
- R7: The ring is full when (tail + 1) mod size equals head. While it is full, req_ready is 0 and nothing is written.
- R8: A head update with a value at most size − 1 replaces the head. A larger value is ignored and leaves the full/not-full state unchanged.
- R9: irq_o is 1 for exactly one cycle: the cycle after the last posting of a back-to-back run, when no new posting is accepted in that cycle. It stays 0 when interrupts were disabled at load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Strobe: capture ring setup and restart pointers |
| cfg_base | input | AW | Ring base byte address |
| cfg_size_m1 | input | QW | Ring size minus one |
| cfg_irq_en | input | 1 | Interrupt enable for this ring |
| req_valid | input | 1 | Completion request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_cid | input | 16 | Command identifier |
| req_status | input | 15 | Status code |
| req_sqid | input | 16 | Originating submission queue id |
| req_sqhead | input | 16 | That submission queue's head |
| req_result | input | 32 | Command-specific result dword |
| hd_valid | input | 1 | Host head-update strobe |
| hd_value | input | QW | New head index |
| wr_valid | output | 1 | Memory write present |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 128 | Formatted entry |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench fills a four-slot ring until it is full. A design that compares against head instead of head − 1 would overwrite an unread slot, and a design whose ready ignores fullness would emit an extra write. It then frees space and posts across the wrap. A design that flips the phase one entry early or late shows a wrong bit 112, and one that takes the address after the increment shifts every address by 16. An out-of-range head update is sent while full: a design that accepts it would raise ready. Interrupt pulses are counted per batch, which catches a design that pulses per entry or ignores the enable.

// File: rtl/cq_poster.sv
module cq_poster #(
  parameter int AW      = 64,
  parameter int QW      = 12,
  parameter int ES_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_base,
  input  logic [QW-1:0] cfg_size_m1,
  input  logic          cfg_irq_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [15:0]   req_cid,
  input  logic [14:0]   req_status,
  input  logic [15:0]   req_sqid,
  input  logic [15:0]   req_sqhead,
  input  logic [31:0]   req_result,
  input  logic          hd_valid,
  input  logic [QW-1:0] hd_value,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [127:0]  wr_data,
  output logic          irq_o
);

  logic          ring_on, irq_en, phase;
  logic [AW-1:0] base;
  logic [QW-1:0] last, tail, head, tail_nxt;
  logic          full, fire, wrap;

  assign wrap      = (tail == last);
  assign tail_nxt  = wrap ? '0 : tail + 1'b1;
  assign full      = (tail_nxt == head);
  assign req_ready = ring_on & ~full & ~cfg_load;
  assign fire      = req_valid & req_ready;
  assign irq_o     = irq_en & wr_valid & ~fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_on <= 1'b0;
      irq_en  <= 1'b0;
      base    <= '0;
      last    <= '0;
      tail    <= '0;
      head    <= '0;
      phase   <= 1'b1;
    end else if (cfg_load) begin
      ring_on <= 1'b1;
      irq_en  <= cfg_irq_en;
      base    <= cfg_base;
      last    <= cfg_size_m1;
      tail    <= '0;
      head    <= '0;
      phase   <= 1'b1;
    end else begin
      if (fire) begin
        tail <= tail_nxt;
        if (wrap) phase <= ~phase;
      end
      if (ring_on && hd_valid && hd_value <= last) head <= hd_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= fire;
      if (fire) begin
        wr_addr <= base + (AW'(tail) << ES_LOG2);
        wr_data <= {req_status, phase, req_cid, req_sqid, req_sqhead, 32'h0, req_result};
      end
    end
  end

  // R7
  no_post_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !wr_valid);

  // R6
  tail_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wrap && !cfg_load) |=> (tail == '0 && phase != $past(phase)));

  // R6
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wrap && !cfg_load) |=> (tail == $past(tail) + 1'b1));

  // R5
  status_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (wr_valid && wr_data[127:113] == $past(req_status) && wr_data[112] == $past(phase)));

  // R8
  bad_head_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_valid && hd_value > last && !cfg_load) |=> $stable(head));

endmodule

// File: tb/cq_poster_bench.sv
module cq_poster_bench;
  localparam int CLK_P = 10;
  localparam int AW = 64, QW = 12;

  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, cfg_irq_en = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [QW-1:0] cfg_size_m1 = '0;
  logic req_valid = 0, req_ready;
  logic [15:0] req_cid = '0, req_sqid = '0, req_sqhead = '0;
  logic [14:0] req_status = '0;
  logic [31:0] req_result = '0;
  logic hd_valid = 0;
  logic [QW-1:0] hd_value = '0;
  logic wr_valid, irq_o;
  logic [AW-1:0] wr_addr;
  logic [127:0] wr_data;

  int checks = 0, errors = 0, irq_cnt = 0;
  logic [AW-1:0]  exp_addr_q[$];
  logic [127:0]   exp_data_q[$];
  logic [AW-1:0] m_base;
  int m_size, m_tail, m_phase;

  always #(CLK_P/2) clk = ~clk;

  cq_poster #(.AW(AW), .QW(QW), .ES_LOG2(4)) u_cq_poster (
    .clk, .rst_n, .cfg_load, .cfg_base, .cfg_size_m1, .cfg_irq_en,
    .req_valid, .req_ready, .req_cid, .req_status, .req_sqid, .req_sqhead,
    .req_result, .hd_valid, .hd_value, .wr_valid, .wr_addr, .wr_data, .irq_o);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare writes against scoreboard, count interrupt pulses
  initial forever begin
    @(negedge clk); #(CLK_P/4);
    if (irq_o) irq_cnt++;
    if (wr_valid) begin
      if (exp_addr_q.size() == 0) chk(0, "R7 unexpected write", wr_addr, 0);
      else begin
        logic [AW-1:0] ea;
        logic [127:0] ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        chk(wr_addr == ea, "R3 address", wr_addr, ea);
        chk(wr_data == ed, "R4 R5 entry", wr_data, ed);
      end
    end
  end

  task automatic load(input logic [AW-1:0] b, input int sm1, input bit ie);
    @(negedge clk);
    cfg_load = 1; cfg_base = b; cfg_size_m1 = QW'(sm1); cfg_irq_en = ie;
    @(negedge clk);
    cfg_load = 0;
    m_base = b; m_size = sm1 + 1; m_tail = 0; m_phase = 1;
  endtask

  task automatic post(input logic [15:0] cid, input logic [14:0] st, input logic [31:0] res);
    @(negedge clk);
    req_valid = 1; req_cid = cid; req_status = st; req_sqid = 16'h0003;
    req_sqhead = cid + 16'h0100; req_result = res;
    #1;
    chk(req_ready == 1'b1, "R6 ready for post", req_ready, 1);
    if (req_ready) begin
      exp_addr_q.push_back(m_base + AW'(m_tail * 16));
      exp_data_q.push_back({st, m_phase[0], cid, 16'h0003, cid + 16'h0100, 32'h0, res});
      m_tail = m_tail + 1;
      if (m_tail == m_size) begin m_tail = 0; m_phase = 1 - m_phase; end
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 0;
  endtask

  task automatic head_upd(input int v);
    @(negedge clk); hd_valid = 1; hd_value = QW'(v);
    @(negedge clk); hd_valid = 0;
  endtask

  initial begin
    int base_irq;
    #(CLK_P*3); rst_n = 1;
    // R1: unconfigured ring refuses requests
    @(negedge clk); req_valid = 1; #1;
    chk(req_ready == 0, "R1 ready before load", req_ready, 0);
    repeat (2) @(negedge clk);
    chk(wr_valid == 0 && irq_o == 0, "R1 no write/irq", {wr_valid, irq_o}, 0);
    req_valid = 0;

    // R2: load four-slot ring with interrupts
    load(64'h1000, 3, 1);
    #1;
    chk(req_ready == 1 && wr_valid == 0 && irq_o == 0, "R2 post-load state", {req_ready, wr_valid, irq_o}, 3'b100);

    // R3 R4 R5 R9: batch of three
    base_irq = irq_cnt;
    post(16'h0011, 15'h0000, 32'hAAAA0001);
    post(16'h0012, 15'h0002, 32'hAAAA0002);
    post(16'h0013, 15'h7FFF, 32'hAAAA0003);
    idle();
    repeat (3) @(negedge clk);
    chk(irq_cnt - base_irq == 1, "R9 one pulse per batch", irq_cnt - base_irq, 1);

    // R7: full at tail 3, head 0
    @(negedge clk); req_valid = 1; #1;
    chk(req_ready == 0, "R7 ready low when full", req_ready, 0);
    @(negedge clk); req_valid = 0;

    // R8: out-of-range head ignored
    head_upd(7); #1;
    chk(req_ready == 0, "R8 bad head ignored", req_ready, 0);
    head_upd(2); #1;
    chk(req_ready == 1, "R8 head accepted", req_ready, 1);

    // R6: wrap, phase flips
    post(16'h0021, 15'h0005, 32'hBBBB0001);
    post(16'h0022, 15'h0006, 32'hBBBB0002);
    idle();
    repeat (2) @(negedge clk); #1;
    chk(req_ready == 0, "R7 full after wrap", req_ready, 0);
    head_upd(1); #1;
    chk(req_ready == 1, "R8 head after wrap", req_ready, 1);
    post(16'h0023, 15'h0001, 32'hBBBB0003);
    idle();

    // R9: interrupts disabled, R2 reload restarts pointers
    load(64'h2000, 1, 0);
    base_irq = irq_cnt;
    post(16'h0031, 15'h0004, 32'hCCCC0001);
    idle();
    repeat (3) @(negedge clk);
    chk(irq_cnt == base_irq, "R9 no irq when disabled", irq_cnt - base_irq, 0);
    chk(exp_addr_q.size() == 0, "R3 all writes seen", exp_addr_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P*20000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule